// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines, filters them through a per-line mask, and chooses one winner. Two priority schemes are available, selected at run time. In fixed order, line 0 ranks highest. In rotating order, the line whose service has just ended drops to the lowest rank. When a winner outranks everything already in service, the block raises one interrupt output to the processor.

On acknowledge, the block returns an 8-bit vector. The vector is a programmable 5-bit base in the upper bits joined to the 3-bit index of the winning line. The same acknowledge marks that line as in service. An in-service line holds off its own request and every lower-ranked request until software writes the end-of-interrupt register.

Software sees three write-only registers, selected by a 2-bit address:
- address 0 holds the mask;
- address 1 holds the configuration;
- address 2 is the end-of-interrupt command.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_out and vec_valid are 0 and vec_out is 0x00. All lines are unmasked, fixed priority is active and the vector base is 0.
- R2: A request held high on an unmasked line, with nothing in service, drives int_out high on the second rising edge after the request is applied.
- R3: Writing address 0 sets the mask, where bit i set to 1 masks line i. A masked line never raises int_out, and it is never the source of a vector.
- R4: In fixed mode (configuration bit 0 = 0), line 0 has the highest priority and line 7 the lowest. The acknowledged line is the lowest-numbered pending unmasked line.
- R5: An acknowledge sampled while int_out is 1 produces the following on the next edge: vec_valid pulses high for exactly one cycle, vec_out = {base, line index} and int_out goes to 0.
- R6: An acknowledge sampled while int_out is 0 is ignored. vec_valid stays 0 and vec_out keeps its previous value.
- R7: int_out stays 0 while every pending unmasked request ranks at or below the highest-priority in-service line.
- R8: A pending request that ranks above every in-service line raises int_out again, so service can nest.
- R9: Any write to address 2 clears the highest-priority in-service bit. int_out then re-evaluates one edge later.
- R10: In rotating mode (configuration bit 0 = 1), the line cleared by end-of-interrupt becomes the lowest priority. The line after it, modulo 8, becomes the highest.
- R11: Configuration bits 7:3 set the vector base, which forms vec_out bits 7:3.
- R12: Requests are level sensitive. Dropping a request before acknowledge returns int_out to 0 two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 8 | Level-sensitive request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mask, 1 configuration, 2 end-of-interrupt |
| reg_wdata | input | 8 | Register write data |
| int_ack | input | 1 | Processor acknowledge, sampled on the rising edge |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector delivered after acknowledge |
| vec_valid | output | 1 | One-cycle strobe marking vec_out as new |

## Verification
The bench builds the block with its defaults: eight lines and an 8-bit vector, which gives a 3-bit index and a 5-bit base. With this width, a mask test can cover one line while two others stay active. The base values chosen (0x15 and 0x07) place distinct patterns in the upper field, so a misplaced index or base shows up in vec_out. Eight lines also give the rotating pointer enough room to separate rotating results from fixed results: line 4 wins over line 0 after a rotation, and line 0 wins again once line 4 drops to last.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;

    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_CFG  = 2'd1,
        REG_EOI  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam int CFG_ROT_BIT = 0;

endpackage

// File: rtl/prio_irq_pick.sv
`timescale 1ns/1ps
// Rotating-priority picker: the line just after low_ptr ranks first.
module prio_irq_pick #(
    parameter int N_LINES = 8,
    localparam int IDX_W = $clog2(N_LINES)
) (
    input  logic [N_LINES-1:0] req,
    input  logic [IDX_W-1:0]   low_ptr,
    output logic               found,
    output logic [IDX_W-1:0]   idx,
    output logic [IDX_W-1:0]   rank
);

    always_comb begin
        found = |req;
        idx   = '0;
        rank  = '0;
        for (int r = N_LINES - 1; r >= 0; r--) begin
            int p;
            p = (int'(low_ptr) + 1 + r) % N_LINES;
            if (req[p]) begin
                idx  = IDX_W'(p);
                rank = IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/prio_irq_cfg.sv
`timescale 1ns/1ps
// Write-only register file: mask, mode and vector base, plus the EOI strobe.
module prio_irq_cfg
    import prio_irq_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(N_LINES),
    localparam int BASE_W = DATA_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [1:0]         addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [N_LINES-1:0] mask,
    output logic               rot,
    output logic [BASE_W-1:0]  base,
    output logic               eoi
);

    typedef struct packed {
        logic [N_LINES-1:0] mask;
        logic               rot;
        logic [BASE_W-1:0]  base;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && addr == REG_MASK) begin
            cfg_d.mask = wdata[N_LINES-1:0];
        end
        if (we && addr == REG_CFG) begin
            cfg_d.rot  = wdata[CFG_ROT_BIT];
            cfg_d.base = wdata[DATA_W-1 -: BASE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask = cfg_q.mask;
    assign rot  = cfg_q.rot;
    assign base = cfg_q.base;
    assign eoi  = we && (addr == REG_EOI);

endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
    parameter int N_LINES = 8,
    parameter int VEC_W   = 8,
    localparam int IDX_W  = $clog2(N_LINES),
    localparam int BASE_W = VEC_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_req,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [VEC_W-1:0]   reg_wdata,
    input  logic               int_ack,
    output logic               int_out,
    output logic [VEC_W-1:0]   vec_out,
    output logic               vec_valid
);

    typedef struct packed {
        logic [N_LINES-1:0] irr;
        logic [N_LINES-1:0] isr;
        logic [IDX_W-1:0]   low_ptr;
        logic               int_o;
        logic [VEC_W-1:0]   vec;
        logic               vld;
    } core_t;

    core_t core_d, core_q;

    logic [N_LINES-1:0] mask;
    logic               rot;
    logic [BASE_W-1:0]  base;
    logic               eoi;

    logic [IDX_W-1:0]   eff_low;
    logic [N_LINES-1:0] pend;
    logic               w_found, s_found;
    logic [IDX_W-1:0]   w_idx, w_rank, s_idx, s_rank;

    prio_irq_cfg #(.N_LINES(N_LINES), .DATA_W(VEC_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .mask  (mask),
        .rot   (rot),
        .base  (base),
        .eoi   (eoi)
    );

    assign eff_low = rot ? core_q.low_ptr : IDX_W'(N_LINES - 1);
    assign pend    = core_q.irr & ~mask;

    // Winner among pending requests.
    prio_irq_pick #(.N_LINES(N_LINES)) u_pick_req (
        .req     (pend),
        .low_ptr (eff_low),
        .found   (w_found),
        .idx     (w_idx),
        .rank    (w_rank)
    );

    // Highest-ranked line currently in service.
    prio_irq_pick #(.N_LINES(N_LINES)) u_pick_svc (
        .req     (core_q.isr),
        .low_ptr (eff_low),
        .found   (s_found),
        .idx     (s_idx),
        .rank    (s_rank)
    );

    always_comb begin
        logic               take;
        logic [N_LINES-1:0] set_v;
        logic [N_LINES-1:0] clr_v;

        core_d     = core_q;
        core_d.irr = irq_req;
        core_d.vld = 1'b0;

        take  = int_ack && core_q.int_o;
        set_v = take ? (N_LINES'(1) << w_idx) : '0;
        clr_v = (eoi && s_found) ? (N_LINES'(1) << s_idx) : '0;

        core_d.isr = (core_q.isr & ~clr_v) | set_v;

        if (eoi && s_found && rot) begin
            core_d.low_ptr = s_idx;
        end

        if (take) begin
            core_d.vec = {base, w_idx};
            core_d.vld = 1'b1;
        end

        core_d.int_o = !take && w_found && (!s_found || (w_rank < s_rank));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q         <= '0;
            core_q.low_ptr <= IDX_W'(N_LINES - 1);
        end else begin
            core_q <= core_d;
        end
    end

    assign int_out   = core_q.int_o;
    assign vec_out   = core_q.vec;
    assign vec_valid = core_q.vld;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module prio_irq_ctrl_chk #(
    parameter int N_LINES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINES-1:0] irq_req,
    input logic               int_ack,
    input logic               int_out,
    input logic               vec_valid
);

    // R5: an acknowledge taken while the interrupt is raised produces a vector strobe
    a_r5_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out) |=> vec_valid);

    // R5: the interrupt output falls once acknowledged
    a_r5_int_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_out) |=> !int_out);

    // R5: the strobe lasts one cycle
    a_r5_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R6: no strobe without an accepted acknowledge
    a_r6_no_vec_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(int_ack && int_out));

    // R2: the interrupt output needs a request two edges earlier
    a_r2_int_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> $past(|irq_req, 2));

endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_LINES(N_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .int_ack   (int_ack),
    .int_out   (int_out),
    .vec_valid (vec_valid)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       int_ack = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .int_ack   (int_ack),
        .int_out   (int_out),
        .vec_out   (vec_out),
        .vec_valid (vec_valid)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_ack();
        int_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 int_out", {7'd0, int_out}, 8'h00);
        chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
        chk("R1 vec_out", vec_out, 8'h00);
    endtask

    task automatic t_ignore_ack();
        do_ack();
        chk("R6 vec_valid idle ack", {7'd0, vec_valid}, 8'h00);
        chk("R6 vec_out idle ack", vec_out, 8'h00);
    endtask

    task automatic t_nested();
        reg_write(2'd1, 8'hA8);            // base 0x15, fixed
        irq_req = 8'b0010_1000;            // lines 3, 5
        wait_n(1);
        chk("R2 not yet after one edge", {7'd0, int_out}, 8'h00);
        wait_n(1);
        chk("R2 int_out raised", {7'd0, int_out}, 8'h01);
        do_ack();
        chk("R4 R5 vector line 3", vec_out, 8'hAB);
        chk("R5 vec_valid", {7'd0, vec_valid}, 8'h01);
        chk("R5 int_out low after ack", {7'd0, int_out}, 8'h00);
        wait_n(1);
        chk("R5 vec_valid one cycle", {7'd0, vec_valid}, 8'h00);
        wait_n(2);
        chk("R7 lower line 5 blocked", {7'd0, int_out}, 8'h00);
        irq_req = 8'b0010_1010;            // add line 1
        wait_n(2);
        chk("R8 nested line 1 raises", {7'd0, int_out}, 8'h01);
        do_ack();
        chk("R8 vector line 1", vec_out, 8'hA9);
        irq_req = 8'b0010_1000;
        reg_write(2'd2, 8'h00);            // clears line 1
        wait_n(2);
        chk("R9 R7 line 3 still in service", {7'd0, int_out}, 8'h00);
        reg_write(2'd2, 8'h00);            // clears line 3
        wait_n(1);
        chk("R9 int after second eoi", {7'd0, int_out}, 8'h01);
        irq_req = 8'b0010_0000;
        wait_n(2);
        do_ack();
        chk("R12 R4 vector line 5", vec_out, 8'hAD);
        reg_write(2'd2, 8'h00);
        irq_req = 8'h00;
        wait_n(2);
    endtask

    task automatic t_level();
        irq_req = 8'h40;
        wait_n(2);
        chk("R12 int high line 6", {7'd0, int_out}, 8'h01);
        irq_req = 8'h00;
        wait_n(2);
        chk("R12 int low after drop", {7'd0, int_out}, 8'h00);
    endtask

    task automatic t_mask();
        reg_write(2'd0, 8'h04);
        irq_req = 8'h04;
        wait_n(4);
        chk("R3 masked line 2 silent", {7'd0, int_out}, 8'h00);
        irq_req = 8'h0C;
        wait_n(2);
        chk("R3 line 3 passes", {7'd0, int_out}, 8'h01);
        do_ack();
        chk("R3 vector skips masked line 2", vec_out, 8'hAB);
        wait_n(1);
        do_ack();
        chk("R6 ack while low ignored", {7'd0, vec_valid}, 8'h00);
        chk("R6 vec_out kept", vec_out, 8'hAB);
        reg_write(2'd2, 8'h00);
        irq_req = 8'h00;
        reg_write(2'd0, 8'h00);
        wait_n(2);
    endtask

    task automatic t_rotate();
        reg_write(2'd1, 8'hA9);            // base 0x15, rotating
        irq_req = 8'h11;                   // lines 0, 4
        wait_n(2);
        do_ack();
        chk("R10 first winner line 0", vec_out, 8'hA8);
        reg_write(2'd2, 8'h00);
        wait_n(1);
        chk("R10 int after eoi", {7'd0, int_out}, 8'h01);
        do_ack();
        chk("R10 line 4 outranks line 0", vec_out, 8'hAC);
        wait_n(2);
        chk("R10 R7 line 0 now below line 4", {7'd0, int_out}, 8'h00);
        reg_write(2'd2, 8'h00);
        wait_n(1);
        do_ack();
        chk("R10 line 0 after line 4 rotates", vec_out, 8'hA8);
        reg_write(2'd2, 8'h00);
        irq_req = 8'h00;
        wait_n(2);
    endtask

    task automatic t_base();
        reg_write(2'd1, 8'h38);            // base 0x07, fixed
        irq_req = 8'h80;
        wait_n(2);
        do_ack();
        chk("R11 base 0x07 line 7", vec_out, 8'h3F);
        reg_write(2'd2, 8'h00);
        irq_req = 8'h90;                   // lines 4, 7
        wait_n(2);
        do_ack();
        chk("R11 R4 fixed line 4", vec_out, 8'h3C);
        reg_write(2'd2, 8'h00);
        irq_req = 8'h00;
        wait_n(2);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_ignore_ack();
        t_nested();
        t_level();
        t_mask();
        t_rotate();
        t_base();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule